// File: doc/BRIEF.md
# MDIO Management Frame Master

This block sits on a simple 32-bit register bus and turns a single write of its command word into one complete management frame on the two-wire MDC/MDIO interface used to configure Ethernet PHYs. It supports both Clause 22 and Clause 45 framing. The bus side exposes five word registers: the command word, a Clause 45 address payload, a write payload, the captured read value and a status word carrying a read-failure flag. The PHY side produces MDC from a parameterised divider of the system clock, drives MDIO through an output and an output enable, and samples the MDIO input.

Software fills the payload registers, writes the command word with its start bit set, and polls the start bit until it reads 0. Sequences of frames, such as a Clause 45 address frame followed by a data frame, are built by software from separate commands. Each frame sends 64 bit periods: a preamble of 32 ones, a two-bit start field, the two-bit opcode, the five-bit port address, the five-bit register or device address, a two-bit turnaround and a 16-bit data phase, most significant bit first.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset every register reads 0, MDC is low and the MDIO output enable is low.
- R2: A command write (byte offset 0x00) with bit 14 set launches exactly one frame of 64 MDC rising edges; bit 14 reads 1 while the frame runs and 0 afterwards, and MDC stays low when no frame runs.
- R3: Every frame starts with 32 ones, followed by start field 00 when command bits [13:12] equal 0 (Clause 45) and 01 for any other value (Clause 22).
- R4: After the start field the frame carries command bits [11:10] as the opcode, bits [9:5] as the port address and bits [4:0] as the register/device address, each most significant bit first.
- R5: When opcode bit 1 is 0 (write-type) the master drives turnaround 10 and then 16 data bits: bits [15:0] of the address register (offset 0x04) for a Clause 45 frame with opcode 00, otherwise bits [15:0] of the write-data register (offset 0x08).
- R6: When opcode bit 1 is 1 (read-type) the master drops the output enable from the first turnaround bit to the end of the frame, and the 16 bits sampled in the data phase appear in bits [15:0] of the read-data register (offset 0x0C), first sampled bit most significant.
- R7: Status bit 0 (offset 0x10) becomes 1 at the end of a read-type frame whose second turnaround bit was sampled high, and becomes 0 at the end of any other frame.
- R8: A command write that arrives while a frame is running is ignored: the stored command fields are unchanged and no further frame follows.
- R9: MDC toggles every HALF_CYC system clocks during a frame, so a frame lasts 128*HALF_CYC clocks; MDIO changes only on a falling MDC edge and is sampled on a rising one.
- R10: The address and write-data registers read back the low 16 bits last written; writes to the read-data and status offsets have no effect.
- R11: A command write with bit 14 clear stores bits [13:0] without starting a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Byte offset of the accessed register |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO value driven by the master |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO value sampled from the line |

## Verification
The hardest situation to reach is a read in which the PHY answers exactly at the turnaround: the failure flag hinges on one sampled bit that sits between a released bus and the data phase. The bench carries a small PHY model that counts falling MDC edges and places its turnaround and data bits on the line by that count, and the sweep over all 32 port addresses alternates present and absent PHYs across every opcode and frame type. A command write injected halfway through a running frame covers the ignore rule.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

    // byte offsets of the register bank
    localparam logic [4:0] OFS_CMD  = 5'h00;
    localparam logic [4:0] OFS_ADR  = 5'h04;
    localparam logic [4:0] OFS_WDAT = 5'h08;
    localparam logic [4:0] OFS_RDAT = 5'h0C;
    localparam logic [4:0] OFS_STAT = 5'h10;

    localparam int START_BIT  = 14;
    localparam int FRAME_BITS = 64;
    localparam int PRE_BITS   = 32;

    // bit positions inside a frame, counted from the first preamble bit
    localparam logic [5:0] TA_FIRST   = 6'd46;
    localparam logic [5:0] TA_SECOND  = 6'd47;
    localparam logic [5:0] DATA_FIRST = 6'd48;
    localparam logic [5:0] LAST_BIT   = 6'd63;

    typedef struct packed {
        logic [1:0] ftype;   // 0: clause 45, else clause 22
        logic [1:0] op;
        logic [4:0] port;
        logic [4:0] dreg;
    } cmd_t;

    typedef struct packed {
        cmd_t        cmd;
        logic [15:0] adr;
        logic [15:0] wdat;
        logic [15:0] rdat;
        logic        fail;
    } bank_t;

    function automatic logic [FRAME_BITS-1:0] build_frame(cmd_t c, logic [15:0] payload);
        logic [1:0] st;
        logic [1:0] ta;
        st = (c.ftype == 2'd0) ? 2'b00 : 2'b01;
        ta = c.op[1] ? 2'b11 : 2'b10;
        return {{PRE_BITS{1'b1}}, st, c.op, c.port, c.dreg, ta, payload};
    endfunction

endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
    parameter int HALF_CYC = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic rise_stb,
    output logic fall_stb
);
    localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          mdc;
    } gen_t;

    gen_t gen_d, gen_q;
    logic toggle;

    always_comb begin
        gen_d  = gen_q;
        toggle = run && (gen_q.cnt == CW'(HALF_CYC - 1));
        if (!run) begin
            gen_d.cnt = '0;
            gen_d.mdc = 1'b0;
        end else if (toggle) begin
            gen_d.cnt = '0;
            gen_d.mdc = ~gen_q.mdc;
        end else begin
            gen_d.cnt = gen_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gen_q <= '0;
        else        gen_q <= gen_d;
    end

    assign mdc      = gen_q.mdc;
    assign rise_stb = toggle && !gen_q.mdc;
    assign fall_stb = toggle &&  gen_q.mdc;

endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
    import mdio_mgmt_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [FRAME_BITS-1:0] frame_in,
    input  logic                  is_read,
    input  logic                  rise_stb,
    input  logic                  fall_stb,
    input  logic                  mdio_i,
    output logic                  busy,
    output logic                  frame_rd,
    output logic                  done,
    output logic                  mdio_o,
    output logic                  mdio_oe,
    output logic [15:0]           cap_data,
    output logic                  ta_fail
);
    typedef struct packed {
        logic                  busy;
        logic                  rd;
        logic [5:0]            bit_cnt;
        logic [FRAME_BITS-1:0] shift;
        logic [15:0]           cap;
        logic                  ta_bad;
    } eng_t;

    eng_t eng_d, eng_q;

    always_comb begin
        eng_d = eng_q;
        done  = eng_q.busy && fall_stb && (eng_q.bit_cnt == LAST_BIT);
        if (start && !eng_q.busy) begin
            eng_d.busy    = 1'b1;
            eng_d.rd      = is_read;
            eng_d.bit_cnt = '0;
            eng_d.shift   = frame_in;
            eng_d.cap     = '0;
            eng_d.ta_bad  = 1'b0;
        end else if (eng_q.busy) begin
            if (rise_stb && eng_q.rd) begin
                if (eng_q.bit_cnt == TA_SECOND)
                    eng_d.ta_bad = mdio_i;
                else if (eng_q.bit_cnt >= DATA_FIRST)
                    eng_d.cap = {eng_q.cap[14:0], mdio_i};
            end
            if (fall_stb) begin
                if (done) begin
                    eng_d.busy = 1'b0;
                end else begin
                    eng_d.bit_cnt = eng_q.bit_cnt + 1'b1;
                    eng_d.shift   = {eng_q.shift[FRAME_BITS-2:0], 1'b0};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) eng_q <= '0;
        else        eng_q <= eng_d;
    end

    assign busy     = eng_q.busy;
    assign frame_rd = eng_q.rd;
    assign mdio_o   = eng_q.busy && eng_q.shift[FRAME_BITS-1];
    assign mdio_oe  = eng_q.busy && !(eng_q.rd && (eng_q.bit_cnt >= TA_FIRST));
    assign cap_data = eng_q.cap;
    assign ta_fail  = eng_q.ta_bad;

endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
    import mdio_mgmt_pkg::*;
#(
    parameter int HALF_CYC = 40
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [4:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    bank_t bank_d, bank_q;
    cmd_t  new_cmd, cmd_cur;
    logic  cmd_hit, launch, new_read;
    logic [15:0]           payload;
    logic [FRAME_BITS-1:0] frame;
    logic  eng_busy, eng_rd, eng_done, eng_ta_fail;
    logic [15:0] eng_cap;
    logic  rise_stb, fall_stb;
    logic  unused_wdata_hi;

    assign unused_wdata_hi = ^reg_wdata[31:16];
    assign cmd_cur         = bank_q.cmd;

    always_comb begin
        bank_d   = bank_q;
        new_cmd  = cmd_t'(reg_wdata[13:0]);
        cmd_hit  = reg_we && (reg_addr == OFS_CMD);
        launch   = cmd_hit && !eng_busy && reg_wdata[START_BIT];
        new_read = new_cmd.op[1];
        payload  = ((new_cmd.ftype == 2'd0) && (new_cmd.op == 2'b00)) ? bank_q.adr : bank_q.wdat;
        frame    = build_frame(new_cmd, payload);

        if (cmd_hit && !eng_busy)
            bank_d.cmd = new_cmd;
        if (reg_we && (reg_addr == OFS_ADR))
            bank_d.adr = reg_wdata[15:0];
        if (reg_we && (reg_addr == OFS_WDAT))
            bank_d.wdat = reg_wdata[15:0];
        if (eng_done) begin
            bank_d.fail = eng_rd && eng_ta_fail;
            if (eng_rd)
                bank_d.rdat = eng_cap;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    always_comb begin
        case (reg_addr)
            OFS_CMD:  reg_rdata = {17'd0, eng_busy, bank_q.cmd};
            OFS_ADR:  reg_rdata = {16'd0, bank_q.adr};
            OFS_WDAT: reg_rdata = {16'd0, bank_q.wdat};
            OFS_RDAT: reg_rdata = {16'd0, bank_q.rdat};
            OFS_STAT: reg_rdata = {31'd0, bank_q.fail};
            default:  reg_rdata = '0;
        endcase
    end

    mdio_mdc_gen #(.HALF_CYC(HALF_CYC)) u_mdc (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (eng_busy),
        .mdc      (mdc),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb)
    );

    mdio_frame_engine u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (launch),
        .frame_in (frame),
        .is_read  (new_read),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb),
        .mdio_i   (mdio_i),
        .busy     (eng_busy),
        .frame_rd (eng_rd),
        .done     (eng_done),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe),
        .cap_data (eng_cap),
        .ta_fail  (eng_ta_fail)
    );

endmodule

// File: rtl/mdio_mgmt_checker.sv
module mdio_mgmt_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe,
    input logic        busy,
    input logic        reg_we,
    input logic [4:0]  reg_addr,
    input logic [13:0] cmd_fields
);
    logic       p_mdc;
    logic [6:0] rise_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_mdc    <= 1'b0;
            rise_cnt <= '0;
        end else begin
            p_mdc <= mdc;
            if (!busy)
                rise_cnt <= '0;
            else if (mdc && !p_mdc)
                rise_cnt <= rise_cnt + 1'b1;
        end
    end

    // R2: management clock parked low between frames
    a_r2_mdc_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc);

    // R2: each frame holds exactly 64 rising edges
    a_r2_sixty_four_rises: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (rise_cnt == 7'd64));

    // R8: command fields frozen while a frame runs
    a_r8_cmd_held_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_we && (reg_addr == 5'h00)) |=> $stable(cmd_fields));

    // R9: driven data only moves on a falling clock
    a_r9_mdio_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (mdio_oe && $past(mdio_oe) && !$fell(mdc)) |-> $stable(mdio_o));

endmodule

bind mdio_mgmt_master mdio_mgmt_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mdc        (mdc),
    .mdio_o     (mdio_o),
    .mdio_oe    (mdio_oe),
    .busy       (eng_busy),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .cmd_fields (cmd_cur)
);

// File: tb/tb_mdio_mgmt_master.sv
`timescale 1ns/1ps
module tb_mdio_mgmt_master;
    localparam int TB_HALF = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    // PHY model state
    int rise_cnt = 0, neg_cnt = 0;
    int rise_base = 0, neg_base = 0;
    bit phy_present = 1;
    logic [15:0] phy_val = '0;
    logic [63:0] obs = '0, obs_oe = '0;

    always #2.5 clk = ~clk;

    mdio_mgmt_master #(.HALF_CYC(TB_HALF)) dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    always @(posedge mdc) begin
        int idx;
        idx = rise_cnt - rise_base;
        if (idx >= 0 && idx < 64) begin
            obs[63-idx]    = mdio_o;
            obs_oe[63-idx] = mdio_oe;
        end
        rise_cnt = rise_cnt + 1;
    end

    always @(negedge mdc) begin
        int k;
        neg_cnt = neg_cnt + 1;
        k = neg_cnt - neg_base;
        if (k == 47)
            mdio_i = !phy_present;
        else if (k >= 48 && k <= 63)
            mdio_i = phy_val[63-k];
        else
            mdio_i = 1'b1;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic run_frame(input logic [1:0] ft, input logic [1:0] op,
                             input logic [4:0] prt, input logic [4:0] rg,
                             input bit present, input logic [15:0] rdv,
                             input logic [15:0] aval, input logic [15:0] wval);
        logic [31:0] v;
        logic [13:0] fields;
        logic [1:0]  st;
        logic [15:0] pay;
        int cnt;
        bit rd;
        fields = {ft, op, prt, rg};
        rd  = op[1];
        st  = (ft == 2'd0) ? 2'b00 : 2'b01;
        pay = (ft == 2'd0 && op == 2'b00) ? aval : wval;
        bus_write(5'h04, {16'hFFFF, aval});
        bus_write(5'h08, {16'h5A5A, wval});
        phy_present = present; phy_val = rdv;
        rise_base = rise_cnt; neg_base = neg_cnt;
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 5'h00; reg_wdata = {17'd0, 1'b1, fields};
        @(negedge clk);
        reg_we = 1'b0;
        #1;
        check(reg_rdata[14] == 1'b1, "R2", "start bit while running", reg_rdata[14], 1);
        cnt = 0;
        while (reg_rdata[14] && cnt < 20000) begin
            cnt++;
            @(negedge clk);
            #1;
        end
        check(cnt == 128*TB_HALF, "R9", "frame length in clocks", cnt, 128*TB_HALF);
        check(rise_cnt - rise_base == 64, "R2", "MDC rising edges", rise_cnt - rise_base, 64);
        check(mdc == 1'b0 && mdio_oe == 1'b0, "R2", "idle mdc/oe", {mdc, mdio_oe}, 0);
        check(obs[63:32] == 32'hFFFF_FFFF, "R3", "preamble", obs[63:32], 32'hFFFF_FFFF);
        check(obs[31:30] == st, "R3", "start field", obs[31:30], st);
        check(obs[29:18] == {op, prt, rg}, "R4", "op/port/reg", obs[29:18], {op, prt, rg});
        if (!rd) begin
            check(obs[17:0] == {2'b10, pay} && obs_oe == '1, "R5", "turnaround+data",
                  {obs_oe[17:0], obs[17:0]}, {18'h3FFFF, 2'b10, pay});
        end else begin
            check(obs_oe[17:0] == '0 && obs_oe[63:18] == '1, "R6", "release pattern",
                  obs_oe, {46'h3FFF_FFFF_FFFF, 18'h0});
            bus_read(5'h0C, v);
            check(v == {16'd0, rdv}, "R6", "captured read data", v, {16'd0, rdv});
        end
        bus_read(5'h10, v);
        check(v == {31'd0, rd && !present}, "R7", "status after frame", v, rd && !present);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        check(mdc == 1'b0 && mdio_oe == 1'b0, "R1", "pins after reset", {mdc, mdio_oe}, 0);
        for (int a = 0; a < 5; a++) begin
            bus_read(5'(a*4), v);
            check(v == 32'd0, "R1", "register after reset", v, 0);
        end

        // R10: payload registers keep the low half, result registers are read-only
        bus_write(5'h04, 32'hDEAD_1234);
        bus_read(5'h04, v);
        check(v == 32'h0000_1234, "R10", "address readback", v, 32'h1234);
        bus_write(5'h08, 32'hCAFE_8765);
        bus_read(5'h08, v);
        check(v == 32'h0000_8765, "R10", "write data readback", v, 32'h8765);
        bus_write(5'h0C, 32'hFFFF_FFFF);
        bus_write(5'h10, 32'hFFFF_FFFF);
        bus_read(5'h0C, v);
        check(v == 32'd0, "R10", "read data not writable", v, 0);
        bus_read(5'h10, v);
        check(v == 32'd0, "R10", "status not writable", v, 0);

        // R11: store without launch
        rise_base = rise_cnt;
        bus_write(5'h00, 32'h0000_2ABC);
        repeat (40) @(negedge clk);
        bus_read(5'h00, v);
        check(v == 32'h0000_2ABC, "R11", "fields stored, start clear", v, 32'h2ABC);
        check(rise_cnt == rise_base, "R11", "no MDC activity", rise_cnt - rise_base, 0);

        // sweep over every port address, cycling frame type and opcode
        for (int i = 0; i < 32; i++) begin
            run_frame(2'(i % 4), 2'((i / 4) % 4), 5'(i), 5'((i * 7 + 3) % 32),
                      (i % 3) != 0, 16'hA5C3 ^ 16'(i * 16'h1357),
                      16'h1000 + 16'(i * 16'h0111), 16'hBEEF ^ 16'(i * 16'h0F0F));
        end

        // R8: command write during a running frame is dropped
        rise_base = rise_cnt; neg_base = neg_cnt;
        phy_present = 1;
        bus_write(5'h00, {17'd0, 1'b1, 2'd1, 2'b01, 5'd9, 5'd4});
        repeat (30) @(negedge clk);
        bus_write(5'h00, 32'h0000_7FFF);
        begin
            int cnt;
            cnt = 0;
            reg_addr = 5'h00;
            #1;
            while (reg_rdata[14] && cnt < 20000) begin
                cnt++;
                @(negedge clk);
                #1;
            end
        end
        repeat (300) @(negedge clk);
        bus_read(5'h00, v);
        check(v == {18'd0, 2'd1, 2'b01, 5'd9, 5'd4}, "R8", "command fields kept", v,
              {18'd0, 2'd1, 2'b01, 5'd9, 5'd4});
        check(rise_cnt - rise_base == 64, "R8", "only one frame", rise_cnt - rise_base, 64);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule